// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the operand offset and the physical memory address for a memory operand of a 16-bit processor that addresses a 1 MB space through 64 KB segments. Each request carries an addressing mode, the current contents of the two base registers (BX, BP) and the two index registers (SI, DI), a displacement with a width flag, an optional segment override and the values of the four segment registers. The block adds the parts that the mode selects, chooses a segment and produces a registered result one clock later.

The segment choice follows the registers that took part in the sum. When BP is one of them, the stack segment is used. Otherwise the data segment is used. A valid override replaces this choice. A short displacement is the low byte of the displacement input, sign-extended to 16 bits. The offset sum wraps at 64 KB, and the physical address (segment value times 16 plus offset) wraps at 1 MB. Decoding of instruction bytes and the memory access itself belong to neighbouring logic.

Top module: `ea_phys_gen`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `outOffset`, `outSeg` and `outPhys` are all zero.
- R2: A request with `reqValid` high and a legal mode (`addrMode` 0 to 4) drives `outValid` high in the next cycle. In every other cycle `outValid` is low.
- R3: Direct mode (`addrMode`=0) uses all 16 bits of `dispIn` as the offset. `dispWide` has no effect in this mode.
- R4: Register-indirect mode (`addrMode`=1) uses one register chosen by `indSel` (0 BX, 1 BP, 2 SI, 3 DI) as the offset, with no displacement.
- R5: Based mode (`addrMode`=2) adds the displacement to BX (`baseSel`=0) or BP (`baseSel`=1).
- R6: Indexed mode (`addrMode`=3) adds the displacement to SI (`idxSel`=0) or DI (`idxSel`=1).
- R7: Based-indexed mode (`addrMode`=4) adds the chosen base register to the chosen index register. The displacement is added only when `dispPresent` is 1.
- R8: In modes 2 to 4, `dispWide`=0 selects `dispIn[7:0]` sign-extended to 16 bits, and the upper byte of `dispIn` is ignored. `dispWide`=1 selects all 16 bits.
- R9: The offset sum wraps modulo 2^16.
- R10: With no override, the segment is SS (`outSeg`=2) when BP takes part in the offset and DS (`outSeg`=3) otherwise. The segment codes are 0 ES, 1 CS, 2 SS, 3 DS.
- R11: When `ovrValid` is 1, `outSeg` equals `ovrSeg`, whatever the mode.
- R12: `outPhys` equals (value of the chosen segment register × 16 + `outOffset`) modulo 2^20. The segment value is the one present with the request.
- R13: A request with `addrMode` 5, 6 or 7 produces no valid output and leaves `outOffset`, `outSeg` and `outPhys` unchanged.
- R14: In a cycle without a request, `outOffset`, `outSeg` and `outPhys` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe |
| addrMode | input | 3 | Addressing mode (0 direct, 1 register-indirect, 2 based, 3 indexed, 4 based-indexed) |
| baseSel | input | 1 | Base register: 0 BX, 1 BP |
| idxSel | input | 1 | Index register: 0 SI, 1 DI |
| indSel | input | 2 | Register for register-indirect mode: 0 BX, 1 BP, 2 SI, 3 DI |
| dispPresent | input | 1 | Based-indexed mode adds the displacement |
| dispWide | input | 1 | 1 selects the 16-bit displacement, 0 the sign-extended low byte |
| dispIn | input | 16 | Displacement |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| ovrValid | input | 1 | Segment override present |
| ovrSeg | input | 2 | Override segment code |
| segEs | input | 16 | ES value |
| segCs | input | 16 | CS value |
| segSs | input | 16 | SS value |
| segDs | input | 16 | DS value |
| outValid | output | 1 | Result valid |
| outOffset | output | 16 | Effective offset |
| outSeg | output | 2 | Chosen segment code |
| outPhys | output | 20 | Physical address |

## Verification
A wrong strobe from the decode shows up one cycle after the request. Two things are visible there: an offset that misses or repeats a register or displacement term, and an `outSeg` that names the wrong segment. An `outPhys` that does not match the reported segment and offset on the same valid cycle points to a fault in the segment multiplexer or the shift-add. A load enable that fires when it should not shows as a changed offset after an idle or illegal-mode cycle. The vector set includes wrap cases for both sums, so that a lost carry or a missing sign extension changes the output value.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_REGIND  = 3'd1,
    MODE_BASED   = 3'd2,
    MODE_INDEXED = 3'd3,
    MODE_BASEIDX = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    IND_BX = 2'd0,
    IND_BP = 2'd1,
    IND_SI = 2'd2,
    IND_DI = 2'd3
  } ind_e;

  // Strobes from the decode to the datapath
  typedef struct packed {
    logic load;
    logic useBase;
    logic baseIsBp;
    logic useIdx;
    logic idxIsDi;
    logic useDisp;
    logic dispShort;
    seg_e segSel;
  } ea_ctrl_t;

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] addrMode,
  input  logic       baseSel,
  input  logic       idxSel,
  input  logic [1:0] indSel,
  input  logic       dispPresent,
  input  logic       dispWide,
  input  logic       ovrValid,
  input  logic [1:0] ovrSeg,
  output ea_ctrl_t   ctrl
);

  logic legal;
  logic bpUsed;

  always_comb begin
    ctrl  = '0;
    legal = 1'b1;
    case (addrMode)
      MODE_DIRECT: begin
        ctrl.useDisp   = 1'b1;
        ctrl.dispShort = 1'b0;
      end
      MODE_REGIND: begin
        case (indSel)
          IND_BX: ctrl.useBase = 1'b1;
          IND_BP: begin
            ctrl.useBase  = 1'b1;
            ctrl.baseIsBp = 1'b1;
          end
          IND_SI: ctrl.useIdx = 1'b1;
          default: begin
            ctrl.useIdx  = 1'b1;
            ctrl.idxIsDi = 1'b1;
          end
        endcase
      end
      MODE_BASED: begin
        ctrl.useBase   = 1'b1;
        ctrl.baseIsBp  = baseSel;
        ctrl.useDisp   = 1'b1;
        ctrl.dispShort = ~dispWide;
      end
      MODE_INDEXED: begin
        ctrl.useIdx    = 1'b1;
        ctrl.idxIsDi   = idxSel;
        ctrl.useDisp   = 1'b1;
        ctrl.dispShort = ~dispWide;
      end
      MODE_BASEIDX: begin
        ctrl.useBase   = 1'b1;
        ctrl.baseIsBp  = baseSel;
        ctrl.useIdx    = 1'b1;
        ctrl.idxIsDi   = idxSel;
        ctrl.useDisp   = dispPresent;
        ctrl.dispShort = ~dispWide;
      end
      default: legal = 1'b0;
    endcase

    bpUsed = ctrl.useBase & ctrl.baseIsBp;
    if (ovrValid)
      ctrl.segSel = seg_e'(ovrSeg);
    else if (bpUsed)
      ctrl.segSel = SEG_SS;
    else
      ctrl.segSel = SEG_DS;

    ctrl.load = reqValid & legal;
  end

endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int OFS_W        = 16,
  parameter int SEG_SHIFT    = 4,
  parameter int DISP_SHORT_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ea_ctrl_t                      ctrl,
  input  logic [OFS_W-1:0]              dispIn,
  input  logic [OFS_W-1:0]              regBx,
  input  logic [OFS_W-1:0]              regBp,
  input  logic [OFS_W-1:0]              regSi,
  input  logic [OFS_W-1:0]              regDi,
  input  logic [OFS_W-1:0]              segEs,
  input  logic [OFS_W-1:0]              segCs,
  input  logic [OFS_W-1:0]              segSs,
  input  logic [OFS_W-1:0]              segDs,
  output logic                          outValid,
  output logic [OFS_W-1:0]              outOffset,
  output logic [1:0]                    outSeg,
  output logic [OFS_W+SEG_SHIFT-1:0]    outPhys
);

  localparam int PHYS_W = OFS_W + SEG_SHIFT;
  localparam int NSEG   = 4;

  logic [OFS_W-1:0]  baseVal;
  logic [OFS_W-1:0]  idxVal;
  logic [OFS_W-1:0]  dispShortExt;
  logic [OFS_W-1:0]  dispVal;
  logic [OFS_W-1:0]  offNext;
  logic [OFS_W-1:0]  segVal;
  logic [PHYS_W-1:0] physNext;
  logic [OFS_W-1:0]  segArr [NSEG];

  // Short displacement widening: the variant depends on the widths
  generate
    if (DISP_SHORT_W < OFS_W) begin : g_sext
      assign dispShortExt = {{(OFS_W-DISP_SHORT_W){dispIn[DISP_SHORT_W-1]}},
                             dispIn[DISP_SHORT_W-1:0]};
    end else begin : g_full
      assign dispShortExt = dispIn;
    end
  endgenerate

  assign baseVal = !ctrl.useBase ? '0 : (ctrl.baseIsBp ? regBp : regBx);
  assign idxVal  = !ctrl.useIdx  ? '0 : (ctrl.idxIsDi  ? regDi : regSi);
  assign dispVal = !ctrl.useDisp ? '0 : (ctrl.dispShort ? dispShortExt : dispIn);

  // Three-operand sum, carries beyond OFS_W are dropped
  assign offNext = baseVal + idxVal + dispVal;

  assign segArr[SEG_ES] = segEs;
  assign segArr[SEG_CS] = segCs;
  assign segArr[SEG_SS] = segSs;
  assign segArr[SEG_DS] = segDs;
  assign segVal = segArr[ctrl.segSel];

  assign physNext = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offNext};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outOffset <= '0;
      outSeg    <= '0;
      outPhys   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outOffset <= offNext;
        outSeg    <= ctrl.segSel;
        outPhys   <= physNext;
      end
    end
  end

endmodule

// File: rtl/ea_phys_gen.sv
module ea_phys_gen
  import ea_pkg::*;
#(
  parameter int OFS_W        = 16,
  parameter int SEG_SHIFT    = 4,
  parameter int DISP_SHORT_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [2:0]                 addrMode,
  input  logic                       baseSel,
  input  logic                       idxSel,
  input  logic [1:0]                 indSel,
  input  logic                       dispPresent,
  input  logic                       dispWide,
  input  logic [OFS_W-1:0]           dispIn,
  input  logic [OFS_W-1:0]           regBx,
  input  logic [OFS_W-1:0]           regBp,
  input  logic [OFS_W-1:0]           regSi,
  input  logic [OFS_W-1:0]           regDi,
  input  logic                       ovrValid,
  input  logic [1:0]                 ovrSeg,
  input  logic [OFS_W-1:0]           segEs,
  input  logic [OFS_W-1:0]           segCs,
  input  logic [OFS_W-1:0]           segSs,
  input  logic [OFS_W-1:0]           segDs,
  output logic                       outValid,
  output logic [OFS_W-1:0]           outOffset,
  output logic [1:0]                 outSeg,
  output logic [OFS_W+SEG_SHIFT-1:0] outPhys
);

  ea_ctrl_t ctrl;

  ea_ctrl u_ctrl (
    .reqValid    (reqValid),
    .addrMode    (addrMode),
    .baseSel     (baseSel),
    .idxSel      (idxSel),
    .indSel      (indSel),
    .dispPresent (dispPresent),
    .dispWide    (dispWide),
    .ovrValid    (ovrValid),
    .ovrSeg      (ovrSeg),
    .ctrl        (ctrl)
  );

  ea_dpath #(
    .OFS_W        (OFS_W),
    .SEG_SHIFT    (SEG_SHIFT),
    .DISP_SHORT_W (DISP_SHORT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .dispIn    (dispIn),
    .regBx     (regBx),
    .regBp     (regBp),
    .regSi     (regSi),
    .regDi     (regDi),
    .segEs     (segEs),
    .segCs     (segCs),
    .segSs     (segSs),
    .segDs     (segDs),
    .outValid  (outValid),
    .outOffset (outOffset),
    .outSeg    (outSeg),
    .outPhys   (outPhys)
  );

endmodule

// File: rtl/ea_phys_gen_chk.sv
module ea_phys_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic [2:0]                 addrMode,
  input logic [1:0]                 indSel,
  input logic [OFS_W-1:0]           dispIn,
  input logic                       ovrValid,
  input logic [1:0]                 ovrSeg,
  input logic [OFS_W-1:0]           segEs,
  input logic [OFS_W-1:0]           segCs,
  input logic [OFS_W-1:0]           segSs,
  input logic [OFS_W-1:0]           segDs,
  input logic                       outValid,
  input logic [OFS_W-1:0]           outOffset,
  input logic [1:0]                 outSeg,
  input logic [OFS_W+SEG_SHIFT-1:0] outPhys
);

  localparam int PHYS_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0]  pEs, pCs, pSs, pDs;
  logic [OFS_W-1:0]  pickSeg;
  logic [PHYS_W-1:0] physRef;

  always_ff @(posedge clk) begin
    pEs <= segEs;
    pCs <= segCs;
    pSs <= segSs;
    pDs <= segDs;
  end

  always_comb begin
    case (outSeg)
      2'd0:    pickSeg = pEs;
      2'd1:    pickSeg = pCs;
      2'd2:    pickSeg = pSs;
      default: pickSeg = pDs;
    endcase
    physRef = {pickSeg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, outOffset};
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> !outValid && outOffset == '0 && outSeg == 2'd0 && outPhys == '0);

  // R2
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rstN) && $past(reqValid) && $past(addrMode) <= 3'd4);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && $past(addrMode) <= 3'd4 |-> outValid);

  // R3
  direct_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && $past(addrMode) == 3'd0 |-> outOffset == $past(dispIn));

  // R10
  direct_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && !$past(ovrValid) && $past(addrMode) == 3'd0
      |-> outSeg == 2'd3);

  // R10
  bp_indirect_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && !$past(ovrValid) && $past(addrMode) == 3'd1
      && $past(indSel) == 2'd1 |-> outSeg == 2'd2);

  // R11
  override_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && $past(ovrValid) && $past(addrMode) <= 3'd4
      |-> outSeg == $past(ovrSeg));

  // R12
  phys_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outPhys == physRef);

  // R13
  illegal_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(reqValid) && $past(addrMode) > 3'd4
      |-> !outValid && $stable(outOffset) && $stable(outPhys));

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(reqValid)
      |-> $stable(outOffset) && $stable(outSeg) && $stable(outPhys));

endmodule

bind ea_phys_gen ea_phys_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .addrMode  (addrMode),
  .indSel    (indSel),
  .dispIn    (dispIn),
  .ovrValid  (ovrValid),
  .ovrSeg    (ovrSeg),
  .segEs     (segEs),
  .segCs     (segCs),
  .segSs     (segSs),
  .segDs     (segDs),
  .outValid  (outValid),
  .outOffset (outOffset),
  .outSeg    (outSeg),
  .outPhys   (outPhys)
);

// File: tb/sim_ea_phys_gen.sv
module sim_ea_phys_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic [2:0]  mode;
    logic        bSel;
    logic        iSel;
    logic [1:0]  ind;
    logic        dp;
    logic        wide;
    logic [15:0] disp;
    logic        ovV;
    logic [1:0]  ovS;
    logic [15:0] expOff;
    logic [1:0]  expSeg;
  } vec_t;

  localparam int NVEC = 15;
  // Register values: BX=1234 BP=F000 SI=0010 DI=FFFF
  // Segment values:  ES=1000 CS=2000 SS=3000 DS=F800
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'hABCD, 1'b0, 2'd0, 16'hABCD, 2'd3}, // R3 short flag ignored, R12 phys wrap
    '{3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h7777, 1'b0, 2'd0, 16'h1234, 2'd3}, // R4 BX
    '{3'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h7777, 1'b0, 2'd0, 16'hF000, 2'd2}, // R4 BP, R10 SS
    '{3'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 16'h0010, 2'd3}, // R4 SI
    '{3'd1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 2'd0, 16'hFFFF, 2'd3}, // R4 DI
    '{3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0100, 1'b0, 2'd0, 16'h1334, 2'd3}, // R5 BX wide
    '{3'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h12F0, 1'b0, 2'd0, 16'hEFF0, 2'd2}, // R5 R8 R9 BP, negative byte
    '{3'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h007F, 1'b0, 2'd0, 16'h008F, 2'd3}, // R6 R8 SI positive byte
    '{3'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'h0002, 1'b0, 2'd0, 16'h0001, 2'd3}, // R6 R9 DI wrap
    '{3'd4, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h5555, 1'b0, 2'd0, 16'h1244, 2'd3}, // R7 BX+SI, disp absent
    '{3'd4, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 16'h0080, 1'b0, 2'd0, 16'hEF7F, 2'd2}, // R7 R8 R9 BP+DI+sext(80)
    '{3'd4, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 16'h1000, 1'b0, 2'd0, 16'h2233, 2'd3}, // R7 BX+DI+1000
    '{3'd4, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd0, 16'hF010, 2'd0}, // R11 BP+SI to ES
    '{3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0000, 1'b1, 2'd1, 16'h0000, 2'd1}, // R11 direct to CS
    '{3'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0000, 1'b1, 2'd3, 16'hF000, 2'd3}  // R11 BP to DS
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [2:0]  addrMode;
  logic        baseSel, idxSel;
  logic [1:0]  indSel;
  logic        dispPresent, dispWide;
  logic [15:0] dispIn;
  logic [15:0] regBx, regBp, regSi, regDi;
  logic        ovrValid;
  logic [1:0]  ovrSeg;
  logic [15:0] segEs, segCs, segSs, segDs;
  logic        outValid;
  logic [15:0] outOffset;
  logic [1:0]  outSeg;
  logic [19:0] outPhys;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_phys_gen u0 (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .addrMode (addrMode),
    .baseSel (baseSel), .idxSel (idxSel), .indSel (indSel),
    .dispPresent (dispPresent), .dispWide (dispWide), .dispIn (dispIn),
    .regBx (regBx), .regBp (regBp), .regSi (regSi), .regDi (regDi),
    .ovrValid (ovrValid), .ovrSeg (ovrSeg),
    .segEs (segEs), .segCs (segCs), .segSs (segSs), .segDs (segDs),
    .outValid (outValid), .outOffset (outOffset), .outSeg (outSeg), .outPhys (outPhys)
  );

  function automatic logic [19:0] physOf(input logic [1:0] s, input logic [15:0] off);
    logic [15:0] sv;
    case (s)
      2'd0:    sv = 16'h1000;
      2'd1:    sv = 16'h2000;
      2'd2:    sv = 16'h3000;
      default: sv = 16'hF800;
    endcase
    return 20'(sv * 20'd16 + 20'(off));
  endfunction

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0:    return "R3";
      3'd1:    return "R4";
      3'd2:    return "R5";
      3'd3:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    reqValid    = 1'b1;
    addrMode    = v.mode;
    baseSel     = v.bSel;
    idxSel      = v.iSel;
    indSel      = v.ind;
    dispPresent = v.dp;
    dispWide    = v.wide;
    dispIn      = v.disp;
    ovrValid    = v.ovV;
    ovrSeg      = v.ovS;
    @(negedge clk);
    reqValid    = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; addrMode = 3'd0; baseSel = 1'b0; idxSel = 1'b0;
    indSel = 2'd0; dispPresent = 1'b0; dispWide = 1'b0; dispIn = 16'h0;
    ovrValid = 1'b0; ovrSeg = 2'd0;
    regBx = 16'h1234; regBp = 16'hF000; regSi = 16'h0010; regDi = 16'hFFFF;
    segEs = 16'h1000; segCs = 16'h2000; segSs = 16'h3000; segDs = 16'hF800;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid",  32'(outValid),  32'h0);
    check("R1 offset", 32'(outOffset), 32'h0);
    check("R1 seg",    32'(outSeg),    32'h0);
    check("R1 phys",   32'(outPhys),   32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", 32'(outValid), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      check("R2 valid", 32'(outValid), 32'h1);
      check({modeTag(VEC[i].mode), " offset"}, 32'(outOffset), 32'(VEC[i].expOff));
      check(VEC[i].ovV ? "R11 seg" : "R10 seg", 32'(outSeg), 32'(VEC[i].expSeg));
      check("R12 phys", 32'(outPhys), 32'(physOf(VEC[i].expSeg, VEC[i].expOff)));
    end

    // R14: idle cycle keeps the last result, valid drops (R2)
    @(negedge clk);
    check("R2 valid drops",  32'(outValid),  32'h0);
    check("R14 offset hold", 32'(outOffset), 32'hF000);
    check("R14 seg hold",    32'(outSeg),    32'h3);
    check("R14 phys hold",   32'(outPhys),   32'(physOf(2'd3, 16'hF000)));

    // R13: illegal modes 5..7 give no result and change nothing
    for (int m = 5; m < 8; m++) begin
      drive('{3'(m), 1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 16'h4321, 1'b1, 2'd0, 16'h0, 2'd0});
      check("R13 no valid",    32'(outValid),  32'h0);
      check("R13 offset hold", 32'(outOffset), 32'hF000);
      check("R13 seg hold",    32'(outSeg),    32'h3);
    end

    // R8: upper byte ignored for short displacement in based mode
    drive('{3'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'hFF01, 1'b0, 2'd0, 16'h0, 2'd0});
    check("R8 upper byte ignored", 32'(outOffset), 32'h1235);

    // R1: asynchronous reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async offset", 32'(outOffset), 32'h0);
    check("R1 async phys",   32'(outPhys),   32'h0);

    summary();
    $finish;
  end

endmodule